// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital control half of a successive-approximation analog-to-digital converter. A falling edge on the convert command, after a high pulse of a minimum number of clocks, starts a conversion. On each clock the block presents a trial code to an external DAC. It samples one comparator bit, then either keeps or clears the trial bit. It works from the most significant bit down to the lowest bit of the selected resolution.

A status output stays high for the whole conversion. Each decided bit leaves on a serial NRZ line, MSB first, during the clock period that follows its decision. At the end the result word is shown on a parallel port in complementary coding, where logic 0 means true. A resolution input, captured when the conversion starts, ends the conversion early at fewer bits. The unresolved low bits then read as their "off" value. One control input inverts only the MSB of the parallel word, which gives complementary two's complement for bipolar ranges.

Top module: `sar_convert_ctrl`

## Requirements
- R1: After reset, `busy` is 0, `ser_out` is 0, `trial_code` is all zeros and the stored result is zero, so `par_out` reads all ones when `twos_sel` is 0.
- R2: In the first busy period `trial_code` has only the MSB set. Each later clock edge decides one bit, from MSB down. The bit is cleared when `cmp_below` is 1 and kept when it is 0. If lower bits remain, the next lower bit is then set as the new trial.
- R3: A conversion starts when `conv_cmd` is sampled low at a clock edge after being sampled high on at least MIN_PULSE consecutive edges. A shorter high pulse is ignored. `busy` is 1 for exactly n+1 clock periods, where n is the resolution, starting at the edge that sees the fall.
- R4: A falling edge of `conv_cmd` that is sampled while `busy` is 1 starts nothing.
- R5: `res_sel` in 1..NBITS picks n. A value of 0 or above NBITS means NBITS. The value is captured at the start edge, so changes during a conversion have no effect. Result bits below bit position NBITS-n are 0, and they read as 1 on `par_out`.
- R6: `par_out` is the bitwise complement of the last completed result. It changes only at the end of a conversion. For example, a true word 0x9896 reads as 0x6769.
- R7: When `twos_sel` is 1, `par_out` bit NBITS-1 is inverted and every other bit is unchanged.
- R8: `ser_out` carries the complement of each decided bit during the clock period after its decision edge, MSB first. It is 0 in the first busy period and whenever `busy` is 0.
- R9: When `busy` is 0, `trial_code` is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| conv_cmd | input | 1 | Convert command; its trailing edge starts a conversion |
| res_sel | input | RES_W | Resolution in bits; 0 or above NBITS means full |
| cmp_below | input | 1 | Comparator: 1 when the analog input is below the trial level |
| twos_sel | input | 1 | Inverts the MSB of the parallel output |
| trial_code | output | NBITS | Trial code to the DAC |
| busy | output | 1 | High during a conversion |
| ser_out | output | 1 | Serial NRZ stream of complemented decided bits |
| par_out | output | NBITS | Complementary parallel result |

## Verification
The hardest situation to reach is a second convert command whose trailing edge lands inside a running conversion while `res_sel` is also being changed. Only correct gating and capture leave both the bit count and the result undisturbed. The stimulus launches a 14-bit conversion and, a few clocks in, raises and drops `conv_cmd` with a valid pulse width while moving `res_sel` to 4. The per-clock reference then shows whether `busy`, the serial stream and the final word still follow the 14-bit run. Short-cycled runs at 1, 13, 14 and 15 bits, and out-of-range selects, exercise the early end and the masking of the low bits.

// File: rtl/sar_ctrl_pkg.sv
package sar_ctrl_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_DECIDE = 2'd1,
        ST_DONE   = 2'd2
    } sar_state_e;
endpackage

// File: rtl/sar_start_detect.sv
module sar_start_detect #(
    parameter int MIN_PULSE = 2,
    localparam int CNT_W = $clog2(MIN_PULSE + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cmd_i,
    input  logic busy_i,
    output logic start_o
);
    typedef struct packed {
        logic             cmd;
        logic [CNT_W-1:0] hi;
    } det_t;

    det_t det_d, det_q;

    always_comb begin
        det_d     = det_q;
        det_d.cmd = cmd_i;
        if (!cmd_i)
            det_d.hi = '0;
        else if (det_q.hi != CNT_W'(MIN_PULSE))
            det_d.hi = det_q.hi + CNT_W'(1);
        start_o = det_q.cmd && !cmd_i && (det_q.hi >= CNT_W'(MIN_PULSE)) && !busy_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) det_q <= '0;
        else        det_q <= det_d;
    end

    // R3: a start is only ever seen with the command low now and high one edge before
    a_r3_trailing_edge: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |-> (!cmd_i && det_q.cmd));
endmodule

// File: rtl/sar_core.sv
module sar_core
    import sar_ctrl_pkg::*;
#(
    parameter int NBITS = 16,
    parameter int RES_W = $clog2(NBITS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [RES_W-1:0] res_sel_i,
    input  logic             cmp_below_i,
    output logic             busy_o,
    output logic [NBITS-1:0] trial_o,
    output logic             ser_o,
    output logic [NBITS-1:0] result_o
);
    localparam logic [NBITS-1:0] MSB_ONE  = {1'b1, {(NBITS-1){1'b0}}};
    localparam logic [NBITS-1:0] ALL_ONES = {NBITS{1'b1}};

    typedef struct packed {
        sar_state_e       state;
        logic [NBITS-1:0] trial;
        logic [NBITS-1:0] result;
        logic [RES_W-1:0] res_n;
        logic [RES_W-1:0] step;
        logic             ser;
    } core_t;

    core_t core_d, core_q;
    logic [NBITS-1:0] cur_bit;
    logic [RES_W-1:0] step_inc;
    logic [NBITS-1:0] low_mask;

    always_comb begin
        core_d   = core_q;
        cur_bit  = MSB_ONE >> core_q.step;
        step_inc = core_q.step + RES_W'(1);
        low_mask = ALL_ONES >> core_q.res_n;
        case (core_q.state)
            ST_IDLE: begin
                if (start_i) begin
                    core_d.state = ST_DECIDE;
                    core_d.trial = MSB_ONE;
                    core_d.step  = '0;
                    core_d.ser   = 1'b0;
                    if (res_sel_i == '0 || res_sel_i > RES_W'(NBITS))
                        core_d.res_n = RES_W'(NBITS);
                    else
                        core_d.res_n = res_sel_i;
                end
            end
            ST_DECIDE: begin
                if (cmp_below_i)
                    core_d.trial = core_q.trial & ~cur_bit;
                core_d.ser  = cmp_below_i;
                core_d.step = step_inc;
                if (step_inc < core_q.res_n)
                    core_d.trial = core_d.trial | (cur_bit >> 1);
                else
                    core_d.state = ST_DONE;
            end
            ST_DONE: begin
                core_d.result = core_q.trial;
                core_d.trial  = '0;
                core_d.ser    = 1'b0;
                core_d.state  = ST_IDLE;
            end
            default: core_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            core_q       <= '0;
            core_q.state <= ST_IDLE;
        end else begin
            core_q <= core_d;
        end
    end

    assign busy_o   = (core_q.state != ST_IDLE);
    assign trial_o  = core_q.trial;
    assign ser_o    = core_q.ser;
    assign result_o = core_q.result;

    // R2: the first trial after a start is the MSB alone
    a_r2_msb_first: assert property (@(posedge clk) disable iff (!rst_n)
        (core_q.state == ST_IDLE && start_i) |=> (trial_o == MSB_ONE));

    // R4: the start qualifier never fires while a conversion runs
    a_r4_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> !start_i);

    // R3: the step count never runs past the captured resolution
    a_r3_step_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (core_q.state == ST_DECIDE) |-> (core_q.step < core_q.res_n));

    // R5: unresolved low bits of a fresh result are zero
    a_r5_low_off: assert property (@(posedge clk) disable iff (!rst_n)
        (core_q.state == ST_DONE) |=> ((result_o & low_mask) == '0));

    // R6: the stored result holds while idle
    a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (core_q.state == ST_IDLE) |=> $stable(result_o));

    // R8 / R9: serial line and trial code quiet while idle
    a_r8_ser_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (!ser_o && trial_o == '0));
endmodule

// File: rtl/sar_out_code.sv
module sar_out_code #(
    parameter int NBITS = 16
) (
    input  logic [NBITS-1:0] result_i,
    input  logic             twos_i,
    output logic [NBITS-1:0] par_o
);
    logic [NBITS-1:0] flip;

    always_comb begin
        flip  = {twos_i, {(NBITS-1){1'b0}}};
        par_o = ~result_i ^ flip;
    end
endmodule

// File: rtl/sar_convert_ctrl.sv
module sar_convert_ctrl #(
    parameter int NBITS     = 16,
    parameter int MIN_PULSE = 2,
    parameter int RES_W     = $clog2(NBITS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             conv_cmd,
    input  logic [RES_W-1:0] res_sel,
    input  logic             cmp_below,
    input  logic             twos_sel,
    output logic [NBITS-1:0] trial_code,
    output logic             busy,
    output logic             ser_out,
    output logic [NBITS-1:0] par_out
);
    logic             start;
    logic [NBITS-1:0] result;

    sar_start_detect #(.MIN_PULSE(MIN_PULSE)) u_start (
        .clk     (clk),
        .rst_n   (rst_n),
        .cmd_i   (conv_cmd),
        .busy_i  (busy),
        .start_o (start)
    );

    sar_core #(.NBITS(NBITS), .RES_W(RES_W)) u_core (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start),
        .res_sel_i   (res_sel),
        .cmp_below_i (cmp_below),
        .busy_o      (busy),
        .trial_o     (trial_code),
        .ser_o       (ser_out),
        .result_o    (result)
    );

    sar_out_code #(.NBITS(NBITS)) u_code (
        .result_i (result),
        .twos_i   (twos_sel),
        .par_o    (par_out)
    );
endmodule

// File: tb/sar_convert_ctrl_tb.sv
module sar_convert_ctrl_tb;
    localparam int N    = 16;
    localparam int MINP = 2;
    localparam int RW   = $clog2(N + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          conv_cmd = 1'b0;
    logic          twos = 1'b0;
    logic [RW-1:0] res_sel = '0;
    logic [N-1:0]  vin = '0;
    logic          cmp_below;
    logic [N-1:0]  trial_code, par_out;
    logic          busy, ser_out;

    int vectors = 0;
    int fails = 0;
    int cycles = 0;
    bit finished = 1'b0;

    // model state
    int           m_prev, m_hi, m_busy, m_j, m_n;
    logic [N-1:0] m_word, m_res;

    always #10 clk = ~clk;

    assign cmp_below = (vin < trial_code);

    sar_convert_ctrl #(.NBITS(N), .MIN_PULSE(MINP)) u_dut (
        .clk(clk), .rst_n(rst_n), .conv_cmd(conv_cmd), .res_sel(res_sel),
        .cmp_below(cmp_below), .twos_sel(twos), .trial_code(trial_code),
        .busy(busy), .ser_out(ser_out), .par_out(par_out)
    );

    task automatic chk(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at cycle %0d", tag, act, exp, cycles);
        end
    endtask

    // behavioural reference, advanced at each rising edge
    always @(posedge clk) begin
        cycles++;
        if (!rst_n) begin
            m_prev = 0; m_hi = 0; m_busy = 0; m_j = 0; m_n = N;
            m_word = '0; m_res = '0;
        end else begin
            if (m_busy != 0) begin
                m_j++;
                if (m_j == m_n + 1) begin
                    m_busy = 0;
                    m_res  = m_word;
                end
            end else if (m_prev != 0 && conv_cmd == 1'b0 && m_hi >= MINP) begin
                m_busy = 1;
                m_j    = 0;
                m_n    = (int'(res_sel) == 0 || int'(res_sel) > N) ? N : int'(res_sel);
                m_word = vin & ~({N{1'b1}} >> m_n);
            end
            if (conv_cmd) m_hi = (m_hi < 1000) ? m_hi + 1 : m_hi;
            else          m_hi = 0;
            m_prev = conv_cmd ? 1 : 0;
        end
    end

    // compare away from the active edge
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            logic [N-1:0] e_trial;
            logic         e_ser;
            e_trial = '0;
            e_ser   = 1'b0;
            if (m_busy != 0) begin
                if (m_j < m_n)
                    e_trial = (m_word & ~({N{1'b1}} >> m_j)) | ({{(N-1){1'b0}}, 1'b1} << (N - 1 - m_j));
                else
                    e_trial = m_word;
                if (m_j >= 1 && m_j <= m_n)
                    e_ser = ~m_word[N - m_j];
            end
            chk("R3/R4 busy", {{(N-1){1'b0}}, busy}, {{(N-1){1'b0}}, (m_busy != 0)});
            chk("R2/R9 trial_code", trial_code, e_trial);
            chk("R8 ser_out", {{(N-1){1'b0}}, ser_out}, {{(N-1){1'b0}}, e_ser});
            chk("R5/R6/R7 par_out", par_out, ~m_res ^ {twos, {(N-1){1'b0}}});
        end
    end

    always @(posedge clk) begin
        if (cycles > 150000 && !finished) begin
            fails++;
            $display("FAIL watchdog expired actual=%0d expected<150000", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    task automatic pulse(input int hi_cycles);
        @(posedge clk); #2 conv_cmd = 1'b1;
        repeat (hi_cycles) @(posedge clk);
        #2 conv_cmd = 1'b0;
    endtask

    task automatic convert(input logic [N-1:0] v, input int res, input int hi_cycles);
        @(posedge clk); #2 vin = v; res_sel = RW'(res);
        pulse(hi_cycles);
        repeat (N + 4) @(posedge clk);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk("R1 par_out", par_out, {N{1'b1}});
        chk("R1 busy/ser", {{(N-2){1'b0}}, busy, ser_out}, '0);
        chk("R1 trial_code", trial_code, '0);

        // R6: worked example word
        convert(16'h9896, 16, 2);
        @(negedge clk);
        chk("R6 complement example", par_out, 16'h6769);

        convert(16'h0000, 16, 2);
        convert(16'hFFFF, 16, 3);
        convert(16'h8000, 16, 2);
        // R5: short-cycled resolutions and out-of-range selects
        convert(16'hBEEF, 13, 2);
        convert(16'hBEEF, 14, 2);
        convert(16'hBEEF, 15, 2);
        convert(16'hFFFF, 1, 2);
        convert(16'h1234, 0, 2);
        convert(16'h4321, 20, 2);

        // R3: pulse shorter than MIN_PULSE is ignored
        @(posedge clk); #2 vin = 16'h0F0F; res_sel = RW'(16);
        pulse(1);
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk("R3 short pulse busy", {{(N-1){1'b0}}, busy}, '0);
        chk("R3 short pulse par", par_out, ~16'h4321);

        // R4/R5: command during busy ignored, res_sel change ignored
        @(posedge clk); #2 vin = 16'hA5C3; res_sel = RW'(14);
        pulse(2);
        repeat (2) @(posedge clk);
        #2 res_sel = RW'(4);
        pulse(3);
        repeat (N + 4) @(posedge clk);
        @(negedge clk);
        chk("R4/R5 busy-time command", par_out, ~(16'hA5C3 & 16'hFFFC));

        // R7: two's complement MSB flip
        @(posedge clk); #2 twos = 1'b1;
        @(negedge clk);
        chk("R7 msb flip", par_out, (~(16'hA5C3 & 16'hFFFC)) ^ 16'h8000);
        convert(16'h7FFF, 16, 2);
        convert(16'h8001, 12, 2);
        @(posedge clk); #2 twos = 1'b0;

        // varied patterns
        for (int i = 0; i < 24; i++) begin
            logic [31:0] s;
            s = 32'(i) * 32'd2654435761 + 32'd12345;
            convert(s[23:8], i % 18, 2 + (i % 3));
        end

        repeat (3) @(posedge clk);
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule